// File: doc/BRIEF.md
# Masked Buffer-Switch Control Decoder

This block drives the switch enables of a row of analog output buffers on a display panel. A single 7-bit control word goes to every buffer slice. Each slice also holds a private mask bit, and combines the word with that bit to produce seven switch enables, phi7 down to phi1. When the mask bit is clear, the slice passes the upper six control bits straight through. When the mask bit is set, the slice is in a read-out role. It forces its two input-select switches off and either passes or inverts the middle four control bits, depending on control bit 0.

The mask bits form a serial chain. Slice 0 sits next to the analog read-out port and is loaded first. Each shift pushes every bit one slice farther away from that port. Marching a single 1 along the chain lets each buffer's held result reach the read-out port in turn. A synchronous clear zeroes the chain in one cycle, which is the state used for normal writes and charge sensing. All switch enables leave the block from flip-flops, so they change cleanly on the clock.

Top module: `maskdec_top`

## Requirements
- R1: While reset is asserted and after it is released, before any shift, every bit of `phiOut` is 0 and every mask bit is 0.
- R2: A slice whose mask bit is 0 drives phi7=0 and phi6..phi1 equal to ctrlBus[6:1], whatever the value of ctrlBus[0]. Every slice sees the same ctrlBus.
- R3: A slice whose mask bit is 1 drives phi7=1 when ctrlBus[0]=1. It also drives phi2=phi1=0 and phi6..phi3 equal to ctrlBus[6:3].
- R4: A slice whose mask bit is 1 drives phi7=1 when ctrlBus[0]=0. It also drives phi2=phi1=0 and phi6..phi3 equal to the bitwise complement of ctrlBus[6:3].
- R5: On a clock edge with maskShift=1 and maskClear=0, slice 0 takes maskIn and slice i (i>0) takes the old mask bit of slice i-1.
- R6: On a clock edge with maskShift=0 and maskClear=0, every mask bit keeps its value, whatever maskIn is.
- R7: On a clock edge with maskClear=1, every mask bit becomes 0, even if maskShift=1 and maskIn=1.
- R8: With REG_OUT=1 (the default), `phiOut` shows the decode of the ctrlBus value and mask bits present before the most recent clock edge. A change on ctrlBus therefore reaches `phiOut` one edge later. A change of mask reaches `phiOut` two edges after the shift or clear request.
- R9: The outputs of slice i occupy phiOut[7*i+6 : 7*i]. Bit 7*i+k-1 carries phi k, so phi1 is the lowest bit of the group and phi7 is the highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlBus | input | 7 | Shared control word for all slices |
| maskIn | input | 1 | Serial mask bit entering slice 0 |
| maskShift | input | 1 | Shift the mask chain on this edge |
| maskClear | input | 1 | Zero all mask bits on this edge (overrides shift) |
| phiOut | output | 7*NUM_SLICES | Registered switch enables, 7 per slice |

## Verification
The assertions assume the inputs are stable at the sampling edge. They also assume that shift and clear requests last exactly as long as they are held, with no pulse narrower than a clock. The bench drives every input on the falling edge and samples on the next falling edge, so setup is never in question. The chain assertions treat clear as dominant over shift. The bench deliberately raises both requests together, so it exercises that overlap rather than avoiding it. It also changes maskIn while shift is low, to show that a hold ignores the serial input.

// File: rtl/maskdec_pkg.sv
package maskdec_pkg;
  localparam int CTRL_W = 7;
  localparam int PHI_W  = 7;

  typedef struct packed {
    logic clr;
    logic shift;
  } maskStrobe_t;
endpackage

// File: rtl/maskdec_ctrl.sv
module maskdec_ctrl
  import maskdec_pkg::*;
(
  input  logic        maskShift,
  input  logic        maskClear,
  output maskStrobe_t strb
);
  // Clear dominates: a shift strobe is never issued alongside a clear.
  always_comb begin
    strb.clr   = maskClear;
    strb.shift = maskShift & ~maskClear;
  end
endmodule

// File: rtl/maskdec_path.sv
module maskdec_path
  import maskdec_pkg::*;
#(
  parameter int NUM_SLICES = 8,
  parameter bit REG_OUT    = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  maskStrobe_t                   strb,
  input  logic                          maskIn,
  input  logic [CTRL_W-1:0]             ctrlBus,
  output logic [NUM_SLICES*PHI_W-1:0]   phiOut
);
  localparam int OUT_W = NUM_SLICES * PHI_W;

  logic [NUM_SLICES-1:0] maskQ;
  logic [OUT_W-1:0]      phiNext;

  // Mask chain: slice 0 nearest the read-out port, filled first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strb.clr) begin
      maskQ <= '0;
    end else if (strb.shift) begin
      if (NUM_SLICES > 1) maskQ <= {maskQ[NUM_SLICES-2:0], maskIn};
      else                maskQ <= maskIn;
    end
  end

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (maskQ == '0));

  // R5
  shift_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (maskQ[0] == $past(maskIn)));

  // R6
  hold_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.shift && !strb.clr) |=> $stable(maskQ));

  generate
    if (NUM_SLICES > 1) begin : g_tail
      // R5
      shift_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.shift |=> (maskQ[NUM_SLICES-1:1] == $past(maskQ[NUM_SLICES-2:0])));
    end
  endgenerate

  // Per-slice decode (bit k-1 of a group is phi k).
  generate
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      logic [PHI_W-1:0] slicePhi;
      always_comb begin
        slicePhi    = '0;
        slicePhi[6] = maskQ[s];
        if (!maskQ[s])       slicePhi[5:0] = ctrlBus[6:1];
        else if (ctrlBus[0]) slicePhi[5:2] = ctrlBus[6:3];
        else                 slicePhi[5:2] = ~ctrlBus[6:3];
      end
      assign phiNext[s*PHI_W +: PHI_W] = slicePhi;

      // R3 R4: a read-out slice never closes its input selects.
      force_low_chk: assert property (@(posedge clk) disable iff (!rstN)
        phiOut[s*PHI_W+6] |-> (phiOut[s*PHI_W+1:s*PHI_W] == 2'b00));
    end
  endgenerate

  generate
    if (REG_OUT) begin : g_reg
      logic [OUT_W-1:0] phiQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) phiQ <= '0;
        else       phiQ <= phiNext;
      end
      assign phiOut = phiQ;

      for (genvar s = 0; s < NUM_SLICES; s++) begin : g_lat
        // R8
        phi7_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
          1'b1 |=> (phiOut[s*PHI_W+6] == $past(maskQ[s])));
      end
    end else begin : g_comb
      assign phiOut = phiNext;
    end
  endgenerate
endmodule

// File: rtl/maskdec_top.sv
module maskdec_top
  import maskdec_pkg::*;
#(
  parameter int NUM_SLICES = 8,
  parameter bit REG_OUT    = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [6:0]                  ctrlBus,
  input  logic                        maskIn,
  input  logic                        maskShift,
  input  logic                        maskClear,
  output logic [NUM_SLICES*7-1:0]     phiOut
);
  maskStrobe_t strb;

  maskdec_ctrl u_ctrl (
    .maskShift (maskShift),
    .maskClear (maskClear),
    .strb      (strb)
  );

  maskdec_path #(.NUM_SLICES(NUM_SLICES), .REG_OUT(REG_OUT)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .maskIn  (maskIn),
    .ctrlBus (ctrlBus),
    .phiOut  (phiOut)
  );
endmodule

// File: tb/maskdec_top_bench.sv
module maskdec_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [6:0]     ctrlBus = '0;
  logic           maskIn = 1'b0;
  logic           maskShift = 1'b0;
  logic           maskClear = 1'b0;
  logic [N*7-1:0] phiOut;

  int errors = 0;
  int checks = 0;
  logic [N-1:0] expMask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maskdec_top #(.NUM_SLICES(N), .REG_OUT(1'b1)) u_maskdec_top (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus), .maskIn(maskIn),
    .maskShift(maskShift), .maskClear(maskClear), .phiOut(phiOut)
  );

  function automatic logic [6:0] expPhi(input logic m, input logic [6:0] t);
    logic [6:0] e;
    e = '0;
    e[6] = m;
    if (!m)        e[5:0] = t[6:1];
    else if (t[0]) e[5:2] = t[6:3];
    else           e[5:2] = 4'(15 - int'(t[6:3]));
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doShift(input logic b, input logic clr);
    maskIn = b; maskShift = 1'b1; maskClear = clr;
    @(negedge clk);
    maskShift = 1'b0; maskClear = 1'b0;
    if (clr) expMask = '0;
    else     expMask = {expMask[N-2:0], b};
  endtask

  function automatic logic [N-1:0] phi7Bits();
    logic [N-1:0] r;
    for (int s = 0; s < N; s++) r[s] = phiOut[s*7+6];
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 in reset", 32'(phiOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'(phiOut), 0);

    // R5: march a single one along the chain
    doShift(1'b1, 1'b0);
    @(negedge clk);
    check("R5 march step 0", 32'(phi7Bits()), 32'(expMask));
    for (int k = 1; k < N; k++) begin
      doShift(1'b0, 1'b0);
      @(negedge clk);
      check("R5 march", 32'(phi7Bits()), 32'(expMask));
    end

    // R6: hold while maskIn toggles, shift low
    doShift(1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      maskIn = ~maskIn;
      @(negedge clk);
      check("R6 hold", 32'(phi7Bits()), 32'(expMask));
    end

    // R7 and R8: clear with shift and maskIn high; outputs lag one edge
    maskIn = 1'b1; maskShift = 1'b1; maskClear = 1'b1;
    @(negedge clk);
    maskShift = 1'b0; maskClear = 1'b0;
    check("R8 old mask still shown", 32'(phi7Bits()), 32'(expMask));
    expMask = '0;
    @(negedge clk);
    check("R7 cleared", 32'(phi7Bits()), 0);

    // R8: ctrlBus change visible only after the next edge
    ctrlBus = 7'h7e;
    #1;
    check("R8 before edge", 32'(phiOut), 0);
    @(negedge clk);
    check("R8 after edge", 32'(phiOut[6:0]), 32'(expPhi(1'b0, 7'h7e)));

    // R2 R3 R4 R9: sweep every mask pattern against every control word
    for (int p = 0; p < (1 << N); p++) begin
      doShift(1'b0, 1'b1);
      for (int b = N - 1; b >= 0; b--) doShift(p[b], 1'b0);
      for (int t = 0; t < 128; t++) begin
        ctrlBus = 7'(t);
        @(negedge clk);
        for (int s = 0; s < N; s++) begin
          // R9: slice s occupies phiOut[7*s+6 : 7*s]
          check(!expMask[s] ? "R2" : (t[0] ? "R3" : "R4"),
                32'(phiOut[s*7 +: 7]), 32'(expPhi(expMask[s], 7'(t))));
        end
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule